// File: doc/BRIEF.md
# Divider setting calculator

This block picks the two fields of a clock divider whose division ratio is a 4-bit mantissa times a power of two. The ratio is (pre + 1) * 2^post, with pre and post each four bits wide. A start strobe supplies a source clock rate and the highest allowed output rate. The block returns the pair of fields whose ratio is the smallest representable value that still slows the source down to the allowed rate or below. The output clock is therefore never faster than requested, and never slower than the field encoding forces it to be.

When the source is faster than the target, the block divides (source - 1) by the target. It uses an internal restoring shift-subtract divider that takes one quotient bit per cycle. It then normalises the quotient the way a floating-point value is normalised: the highest set bit fixes the exponent, and the four bits below and including it form the mantissa. Two cases finish on the first cycle: a source no faster than the target, and a zero target. A ratio too large for a 4-bit exponent is reported as an error. The fields are held until the next calculation completes.

Top module: `clkdiv_setting_calc`

## Requirements
- R1: While reset is asserted and after it is released, pre_o, post_o, err_o and done_o are all 0 until the first calculation completes.
- R2: A start with max_rate nonzero and src_rate <= max_rate yields pre_o=0, post_o=0 and err_o=0, with done_o high right after the clock edge that samples start.
- R3: A start with max_rate equal to 0 yields err_o=1, pre_o=0 and post_o=0, with done_o high right after the clock edge that samples start. No division is started.
- R4: In every other case the block computes q = (src_rate - 1) / max_rate by integer division. done_o rises right after the 34th rising edge, counting the edge that samples start as the first.
- R5: If the highest set bit of q is at 1-based position 4 or lower, post_o=0 and pre_o=q.
- R6: If that position n is above 4, post_o=n-4 and pre_o=q shifted right by post_o, so pre_o lies in 8..15.
- R7: If n-4 is 16 or more, err_o=1 and both fields read 0.
- R8: When err_o=0, (pre_o+1)*2^post_o is the smallest value of that form, with pre_o and post_o in 0..15, that is at least the ceiling of src_rate/max_rate.
- R9: done_o is high for exactly one cycle per calculation. A start sampled while done_o is high is ignored.
- R10: A start sampled while a division is running is ignored. The running calculation finishes with its own operands and its own timing.
- R11: pre_o, post_o and err_o change only in a cycle in which done_o is high. Input changes without an accepted start leave them untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation with the present rates |
| src_rate | input | 32 | Source clock rate |
| max_rate | input | 32 | Highest allowed divided rate |
| pre_o | output | 4 | Mantissa field; the ratio uses pre_o + 1 |
| post_o | output | 4 | Exponent field; the ratio uses 2^post_o |
| done_o | output | 1 | One-cycle pulse when the fields are valid |
| err_o | output | 1 | No representable setting exists for the last request |

## Verification
The assertions check the following on every cycle: the fields are held between done pulses, done_o lasts a single cycle, an error forces zero fields, and the two single-cycle cases answer on the next edge. Inside the divider, they check that it is never reloaded while busy or fed a zero divisor. They also check that every normalised result covers the quotient. Only the bench scenarios can show that the quotient itself is right, that the chosen setting is the minimal one across a spread of rate pairs, and that the 34-cycle latency and the edges of the exponent range, q = 2^19 - 1 against q = 2^19, come out as required.

// File: rtl/clkcalc_pkg.sv
package clkcalc_pkg;
    typedef enum logic {
        CC_IDLE = 1'b0,
        CC_RUN  = 1'b1
    } cc_state_e;
endpackage

// File: rtl/cc_shift_divider.sv
module cc_shift_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         valid,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          valid;
        logic [CW-1:0] cnt;
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
    } dv_t;

    dv_t cur_q, nxt_d;
    logic [W:0] trial_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        trial_d     = {cur_q.rem[W-1:0], cur_q.quo[W-1]};
        if (load) begin
            nxt_d.busy = 1'b1;
            nxt_d.cnt  = CW'(W);
            nxt_d.rem  = '0;
            nxt_d.quo  = dividend;
            nxt_d.dvs  = divisor;
        end else if (cur_q.busy) begin
            if (trial_d >= {1'b0, cur_q.dvs}) begin
                nxt_d.rem = trial_d - {1'b0, cur_q.dvs};
                nxt_d.quo = {cur_q.quo[W-2:0], 1'b1};
            end else begin
                nxt_d.rem = trial_d;
                nxt_d.quo = {cur_q.quo[W-2:0], 1'b0};
            end
            nxt_d.cnt = cur_q.cnt - CW'(1);
            if (cur_q.cnt == CW'(1)) begin
                nxt_d.busy  = 1'b0;
                nxt_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign busy     = cur_q.busy;
    assign valid    = cur_q.valid;
    assign quotient = cur_q.quo;

    // R10: the controller never reloads a running division
    p_no_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);
    // R3: a zero target never reaches the divider
    p_nonzero_divisor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (divisor != '0));
    // R4: a result only follows a running division
    p_valid_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(busy));
endmodule

// File: rtl/cc_normalise.sv
module cc_normalise #(
    parameter int W      = 32,
    parameter int MANT_W = 4,
    parameter int EXP_W  = 4
) (
    input  logic [W-1:0]      q,
    output logic [MANT_W-1:0] pre,
    output logic [EXP_W-1:0]  post,
    output logic              overflow
);
    localparam int NW = $clog2(W + 1);

    logic [NW-1:0] msb_pos;
    logic [NW-1:0] shift_amt;
    logic [W-1:0]  shifted;

    always_comb begin
        msb_pos = '0;
        for (int i = 0; i < W; i++) begin
            if (q[i]) msb_pos = NW'(i + 1);
        end
    end

    always_comb begin
        pre       = '0;
        post      = '0;
        overflow  = 1'b0;
        shift_amt = '0;
        shifted   = q;
        if (int'(msb_pos) <= MANT_W) begin
            pre = q[MANT_W-1:0];
        end else begin
            shift_amt = msb_pos - NW'(MANT_W);
            if (int'(shift_amt) >= (1 << EXP_W)) begin
                overflow = 1'b1;
            end else begin
                shifted = q >> shift_amt;
                pre     = shifted[MANT_W-1:0];
                post    = shift_amt[EXP_W-1:0];
            end
        end
    end
endmodule

// File: rtl/clkdiv_setting_calc.sv
module clkdiv_setting_calc #(
    parameter int RATE_W = 32,
    parameter int MANT_W = 4,
    parameter int EXP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] src_rate,
    input  logic [RATE_W-1:0] max_rate,
    output logic [MANT_W-1:0] pre_o,
    output logic [EXP_W-1:0]  post_o,
    output logic              done_o,
    output logic              err_o
);
    import clkcalc_pkg::*;

    localparam int XW = RATE_W + MANT_W + (1 << EXP_W);

    typedef struct packed {
        cc_state_e         state;
        logic [MANT_W-1:0] pre;
        logic [EXP_W-1:0]  post;
        logic              err;
        logic              done;
    } ctl_t;

    ctl_t cur_q, nxt_d;
    logic              load_d;
    logic              div_busy, div_valid;
    logic [RATE_W-1:0] quot;
    logic [MANT_W-1:0] norm_pre;
    logic [EXP_W-1:0]  norm_post;
    logic              norm_ovf;
    logic              accept;

    assign accept = start && (cur_q.state == CC_IDLE) && !cur_q.done;

    cc_shift_divider #(.W(RATE_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_d),
        .dividend (src_rate - RATE_W'(1)),
        .divisor  (max_rate),
        .busy     (div_busy),
        .valid    (div_valid),
        .quotient (quot)
    );

    cc_normalise #(.W(RATE_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_norm (
        .q        (quot),
        .pre      (norm_pre),
        .post     (norm_post),
        .overflow (norm_ovf)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        load_d     = 1'b0;
        case (cur_q.state)
            CC_IDLE: begin
                if (accept) begin
                    if (max_rate == '0) begin
                        nxt_d.err  = 1'b1;
                        nxt_d.pre  = '0;
                        nxt_d.post = '0;
                        nxt_d.done = 1'b1;
                    end else if (src_rate <= max_rate) begin
                        nxt_d.err  = 1'b0;
                        nxt_d.pre  = '0;
                        nxt_d.post = '0;
                        nxt_d.done = 1'b1;
                    end else begin
                        load_d      = 1'b1;
                        nxt_d.state = CC_RUN;
                    end
                end
            end
            CC_RUN: begin
                if (div_valid) begin
                    nxt_d.pre   = norm_pre;
                    nxt_d.post  = norm_post;
                    nxt_d.err   = norm_ovf;
                    nxt_d.done  = 1'b1;
                    nxt_d.state = CC_IDLE;
                end
            end
            default: nxt_d.state = CC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{state: CC_IDLE, pre: '0, post: '0, err: 1'b0, done: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign pre_o  = cur_q.pre;
    assign post_o = cur_q.post;
    assign err_o  = cur_q.err;
    assign done_o = cur_q.done;

    // R11: fields only move together with a done pulse
    p_hold_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({pre_o, post_o, err_o}));
    // R9: done lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7: an error carries zero fields
    p_err_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (pre_o == '0 && post_o == '0));
    // R3: zero target answers on the next edge with an error
    p_zero_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && max_rate == '0) |=> (done_o && err_o));
    // R2: slow source answers on the next edge with zero fields
    p_slow_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && max_rate != '0 && src_rate <= max_rate)
        |=> (done_o && !err_o && pre_o == '0 && post_o == '0));
    // R8: a normalised setting always covers the quotient
    p_ratio_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_valid && !norm_ovf)
        |-> (((XW'(norm_pre) + XW'(1)) << norm_post) > XW'(quot)));
    // R10: the divider stays busy only while the controller runs
    p_busy_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> (cur_q.state == CC_RUN));
endmodule

// File: tb/sim_clkdiv_setting_calc.sv
module sim_clkdiv_setting_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_rate = '0;
    logic [31:0] max_rate = '0;
    logic [3:0]  pre_o, post_o;
    logic        done_o, err_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    clkdiv_setting_calc u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_rate(src_rate), .max_rate(max_rate),
        .pre_o(pre_o), .post_o(post_o), .done_o(done_o), .err_o(err_o)
    );

    // {src, max, pre, post, err, quick}
    localparam int NV = 14;
    localparam logic [73:0] VEC [NV] = '{
        {32'd100,        32'd100,     4'd0,  4'd0, 1'b0, 1'b1},
        {32'd50,         32'd100,     4'd0,  4'd0, 1'b0, 1'b1},
        {32'd0,          32'd5,       4'd0,  4'd0, 1'b0, 1'b1},
        {32'd77,         32'd0,       4'd0,  4'd0, 1'b1, 1'b1},
        {32'd101,        32'd100,     4'd1,  4'd0, 1'b0, 1'b0},
        {32'd7,          32'd2,       4'd3,  4'd0, 1'b0, 1'b0},
        {32'd1600,       32'd100,     4'd15, 4'd0, 1'b0, 1'b0},
        {32'd1601,       32'd100,     4'd8,  4'd1, 1'b0, 1'b0},
        {32'd66000000,   32'd1000000, 4'd8,  4'd3, 1'b0, 1'b0},
        {32'd24000000,   32'd100000,  4'd14, 4'd4, 1'b0, 1'b0},
        {32'd524288,     32'd1,       4'd15, 4'd15,1'b0, 1'b0},
        {32'd524289,     32'd1,       4'd0,  4'd0, 1'b1, 1'b0},
        {32'd200000000,  32'd3,       4'd0,  4'd0, 1'b1, 1'b0},
        {32'hFFFFFFFF,   32'd1,       4'd0,  4'd0, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // independent oracle: first (m, e) in ascending exponent then mantissa
    task automatic oracle(input logic [31:0] s, input logic [31:0] m,
                          output logic [3:0] p, output logic [3:0] e, output logic er);
        longint need;
        bit found = 0;
        p = 0; e = 0; er = 0;
        if (m == 0) begin
            er = 1;
        end else begin
            need = (s <= m) ? 1 : (longint'(s) + longint'(m) - 1) / longint'(m);
            for (int ei = 0; ei < 16 && !found; ei++)
                for (int mi = 0; mi < 16 && !found; mi++)
                    if ((longint'(mi + 1) << ei) >= need) begin
                        found = 1; p = 4'(mi); e = 4'(ei);
                    end
            if (!found) er = 1;
        end
    endtask

    task automatic run(input logic [31:0] s, input logic [31:0] m, output int lat);
        @(negedge clk);
        src_rate = s; max_rate = m; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done_o && lat < 100) begin
            @(posedge clk); @(negedge clk); lat++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [3:0] rp, re;
        logic rer;
        logic [3:0] keep_pre, keep_post;
        logic keep_err;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk({pre_o, post_o, err_o, done_o} == 0, "R1", "fields during reset",
            {pre_o, post_o, err_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({pre_o, post_o, err_o, done_o} == 0, "R1", "fields after reset",
            {pre_o, post_o, err_o, done_o}, 0);

        // vector table: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [31:0] vs, vm;
            logic [3:0]  vp, vpo;
            logic        ve, vq;
            {vs, vm, vp, vpo, ve, vq} = VEC[i];
            run(vs, vm, lat);
            chk(lat < 100, "R4", "done seen", lat, 34);
            chk(lat == (vq ? 1 : 34), vq ? "R2/R3" : "R4", "latency", lat, vq ? 1 : 34);
            chk(pre_o == vp, "R5/R6", "pre field", pre_o, vp);
            chk(post_o == vpo, "R5/R6", "post field", post_o, vpo);
            chk(err_o == ve, ve ? "R7" : "R3", "error flag", err_o, ve);
            oracle(vs, vm, rp, re, rer);
            chk(err_o == rer && pre_o == rp && post_o == re, "R8", "minimal setting",
                {err_o, pre_o, post_o}, {rer, rp, re});
            @(negedge clk);
            chk(!done_o, "R9", "done single cycle", done_o, 0);
        end

        // R11: input changes without start leave the fields alone
        keep_pre = pre_o; keep_post = post_o; keep_err = err_o;
        src_rate = 32'd123456; max_rate = 32'd7;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(!done_o && pre_o == keep_pre && post_o == keep_post && err_o == keep_err,
                "R11", "hold without start", {done_o, pre_o, post_o, err_o},
                {1'b0, keep_pre, keep_post, keep_err});
        end

        // establish a known result: pre=1 post=0
        run(32'd101, 32'd100, lat);
        chk(pre_o == 1 && post_o == 0, "R5", "pre for q=1", pre_o, 1);

        // R10 and R11: start during a running division
        @(negedge clk);
        src_rate = 32'd66000000; max_rate = 32'd1000000; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0; lat = 1;
        repeat (5) begin @(posedge clk); @(negedge clk); lat++; end
        src_rate = 32'd1601; max_rate = 32'd100; start = 1'b1;
        @(posedge clk); @(negedge clk); lat++;
        start = 1'b0;
        chk(pre_o == 1 && post_o == 0 && !done_o, "R11", "old fields held while busy",
            {pre_o, post_o}, {4'd1, 4'd0});
        while (!done_o && lat < 100) begin @(posedge clk); @(negedge clk); lat++; end
        chk(lat == 34, "R10", "latency with ignored start", lat, 34);
        chk(pre_o == 8 && post_o == 3 && !err_o, "R10", "first operands kept",
            {pre_o, post_o}, {4'd8, 4'd3});
        @(negedge clk);
        chk(!done_o, "R10", "no second done", done_o, 0);

        // R9: start held through the done cycle gives one answer only
        @(negedge clk);
        src_rate = 32'd10; max_rate = 32'd20; start = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(done_o && pre_o == 0 && post_o == 0, "R2", "quick answer", done_o, 1);
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        chk(!done_o, "R9", "start in done cycle ignored", done_o, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule